// File: doc/BRIEF.md
# Transmit Payload Serial Input Interface

This block sits on the transmit side between the local terminal equipment and the framer core. It receives the terminal's payload as a serial bit stream and merges it with overhead bits into one registered output stream, one bit for each line-rate enable. The stream is built from repeating blocks of `FRAME_BITS` bit slots. Slot 0 of each block carries overhead and the remaining slots carry payload. A companion flag marks the overhead slot for the core.

A single timing output, `txTiming`, plays one of two roles. With `clkMode` low it is a strobe that goes high for the whole bit period just before an overhead slot is taken. With `clkMode` high it is a gapped payload clock. The clock goes high at the start of each bit period that ends in a payload slot and falls at mid-period. The terminal launches its next payload bit on that falling edge, and the block samples it at the next bit start. No pulse is made in the period that leads to an overhead slot.

The overhead bit can come from three places. With `ohFromSer` high it is taken from the serial input in the same way as payload. With `ohFromSer` low, `ohUseInt` chooses between a fixed internal value (`OH_FILL`) and the dedicated `ohIn` pin. In both of those cases the serial input is ignored in the overhead slot.

Top module: `tx_payload_in`

## Requirements
- R1: After synchronous reset `txOut`, `txOutOh` and `txTiming` are low, and the first `bitEn` after reset takes slot 0, which is an overhead slot.
- R2: Slots repeat with a period of `FRAME_BITS` (default 85). One overhead slot is followed by `FRAME_BITS-1` payload slots. `txOutOh` is 1 while `txOut` holds an overhead bit and 0 while it holds a payload bit.
- R3: In a payload slot, `serIn` is sampled in the cycle where `bitEn` is high. Its value is on `txOut` from the next cycle and is held until the next `bitEn`.
- R4: With `clkMode`=0, `txTiming` goes high at the `bitEn` that leaves exactly one slot before an overhead slot, and goes low at the `bitEn` that takes that overhead slot. It is low in every other period and is not changed by `midEn`.
- R5: With `clkMode`=1, `txTiming` goes high at each `bitEn` whose next slot is payload and goes low at the following `midEn`. It stays low for the whole period that precedes an overhead slot.
- R6: With `ohFromSer`=1, the overhead bit is `serIn` sampled at the `bitEn` of slot 0.
- R7: With `ohFromSer`=0 and `ohUseInt`=1, the overhead bit equals the parameter `OH_FILL` (default 1), whatever `serIn` and `ohIn` are.
- R8: With `ohFromSer`=0 and `ohUseInt`=0, the overhead bit is `ohIn` sampled at the `bitEn` of slot 0, whatever `serIn` is.
- R9: `txOut` and `txOutOh` change only in the cycle after `bitEn`, and `txTiming` changes only in the cycle after `bitEn` or `midEn`. Input changes between enables have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bitEn | input | 1 | Line-rate enable; one-cycle pulse at the start of each bit period |
| midEn | input | 1 | One-cycle pulse at mid bit period; never high together with bitEn |
| clkMode | input | 1 | Role of txTiming: 0 overhead strobe, 1 gapped payload clock |
| ohFromSer | input | 1 | 1: overhead bits come from serIn |
| ohUseInt | input | 1 | When ohFromSer is 0: 1 uses OH_FILL, 0 uses ohIn |
| serIn | input | 1 | Serial payload (and optional overhead) from the terminal |
| ohIn | input | 1 | Dedicated overhead bit input |
| txOut | output | 1 | Merged output bit to the framer core |
| txOutOh | output | 1 | High while txOut holds an overhead bit |
| txTiming | output | 1 | Overhead strobe or gapped payload clock |

## Verification
Every result is registered once. `txOut`, `txOutOh` and the rising or strobe level of `txTiming` are due in the cycle that follows the `bitEn` cycle. The payload-clock fall is due in the cycle that follows `midEn`. The bench drives all inputs on the falling clock edge and reads each result on the falling edge one cycle after the enable that caused it. It reads the same outputs again in the idle cycles between enables, after `serIn` has been flipped, to confirm nothing moved. A bench model of the slot counter, kept apart from the design, gives the expected overhead position and the expected level of the timing pin for every bit period.

// File: rtl/tx_payload_in_pkg.sv
package tx_payload_in_pkg;
  // Strobes from the slot control to the datapath
  typedef struct packed {
    logic bitTick;  // a bit period starts: take a bit now
    logic midTick;  // middle of the bit period
    logic ohSlot;   // the slot taken at this bitTick is overhead
    logic preOh;    // the slot after this one is overhead
  } txStrobe_t;
endpackage

// File: rtl/tx_payload_in_ctrl.sv
module tx_payload_in_ctrl
  import tx_payload_in_pkg::*;
#(
  parameter int FRAME_BITS = 85
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      bitEn,
  input  logic      midEn,
  output txStrobe_t strobe
);
  localparam int SLOT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_BITS - 1);

  logic [SLOT_W-1:0] slot;
  logic lastSlot;

  assign lastSlot = (slot == LAST_SLOT);

  // slot = index of the slot taken at the next bitEn
  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= '0;
    end else if (bitEn) begin
      slot <= lastSlot ? '0 : slot + 1'b1;
    end
  end

  always_comb begin
    strobe.bitTick = bitEn;
    strobe.midTick = midEn & ~bitEn;
    strobe.ohSlot  = (slot == '0);
    strobe.preOh   = lastSlot;
  end
endmodule

// File: rtl/tx_payload_in_data.sv
module tx_payload_in_data
  import tx_payload_in_pkg::*;
#(
  parameter logic OH_FILL = 1'b1
) (
  input  logic      clk,
  input  logic      rst,
  input  txStrobe_t strobe,
  input  logic      clkMode,
  input  logic      ohFromSer,
  input  logic      ohUseInt,
  input  logic      serIn,
  input  logic      ohIn,
  output logic      txOut,
  output logic      txOutOh,
  output logic      txTiming
);
  logic ohBit;
  logic nextBit;
  logic nextTiming;

  always_comb begin
    if (ohFromSer)     ohBit = serIn;
    else if (ohUseInt) ohBit = OH_FILL;
    else               ohBit = ohIn;
    nextBit = strobe.ohSlot ? ohBit : serIn;
    // strobe mode: high before overhead; clock mode: high before payload
    nextTiming = clkMode ? ~strobe.preOh : strobe.preOh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txOut    <= 1'b0;
      txOutOh  <= 1'b0;
      txTiming <= 1'b0;
    end else if (strobe.bitTick) begin
      txOut    <= nextBit;
      txOutOh  <= strobe.ohSlot;
      txTiming <= nextTiming;
    end else if (strobe.midTick && clkMode) begin
      txTiming <= 1'b0;  // falling edge: terminal launches next bit
    end
  end
endmodule

// File: rtl/tx_payload_in.sv
module tx_payload_in
  import tx_payload_in_pkg::*;
#(
  parameter int   FRAME_BITS = 85,
  parameter logic OH_FILL    = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic bitEn,
  input  logic midEn,
  input  logic clkMode,
  input  logic ohFromSer,
  input  logic ohUseInt,
  input  logic serIn,
  input  logic ohIn,
  output logic txOut,
  output logic txOutOh,
  output logic txTiming
);
  txStrobe_t strobe;

  tx_payload_in_ctrl #(.FRAME_BITS(FRAME_BITS)) ctrlI (
    .clk    (clk),
    .rst    (rst),
    .bitEn  (bitEn),
    .midEn  (midEn),
    .strobe (strobe)
  );

  tx_payload_in_data #(.OH_FILL(OH_FILL)) dataI (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .clkMode   (clkMode),
    .ohFromSer (ohFromSer),
    .ohUseInt  (ohUseInt),
    .serIn     (serIn),
    .ohIn      (ohIn),
    .txOut     (txOut),
    .txOutOh   (txOutOh),
    .txTiming  (txTiming)
  );
endmodule

// File: rtl/tx_payload_in_chk.sv
module tx_payload_in_chk #(
  parameter logic OH_FILL = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic bitEn,
  input logic midEn,
  input logic clkMode,
  input logic ohFromSer,
  input logic ohUseInt,
  input logic serIn,
  input logic ohIn,
  input logic txOut,
  input logic txOutOh,
  input logic txTiming
);
  assert_payload_R3: assert property (@(posedge clk) disable iff (rst)
    bitEn |=> (txOutOh || txOut == $past(serIn)));

  assert_strobe_leads_R4: assert property (@(posedge clk) disable iff (rst)
    (bitEn && !clkMode && txTiming) |=> txOutOh);

  assert_clock_falls_R5: assert property (@(posedge clk) disable iff (rst)
    (midEn && !bitEn && clkMode) |=> !txTiming);

  assert_oh_serial_R6: assert property (@(posedge clk) disable iff (rst)
    (bitEn && ohFromSer) |=> (txOut == $past(serIn)));

  assert_oh_fill_R7: assert property (@(posedge clk) disable iff (rst)
    (bitEn && !ohFromSer && ohUseInt) |=> (!txOutOh || txOut == OH_FILL));

  assert_oh_pin_R8: assert property (@(posedge clk) disable iff (rst)
    (bitEn && !ohFromSer && !ohUseInt) |=> (!txOutOh || txOut == $past(ohIn)));

  assert_data_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !bitEn |=> ($stable(txOut) && $stable(txOutOh)));

  assert_timing_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (!bitEn && !midEn) |=> $stable(txTiming));
endmodule

bind tx_payload_in tx_payload_in_chk #(.OH_FILL(OH_FILL)) chkI (
  .clk       (clk),
  .rst       (rst),
  .bitEn     (bitEn),
  .midEn     (midEn),
  .clkMode   (clkMode),
  .ohFromSer (ohFromSer),
  .ohUseInt  (ohUseInt),
  .serIn     (serIn),
  .ohIn      (ohIn),
  .txOut     (txOut),
  .txOutOh   (txOutOh),
  .txTiming  (txTiming)
);

// File: tb/tx_payload_in_test.sv
`timescale 1ns/1ps
module tx_payload_in_test;
  localparam int   FRAME_BITS = 85;
  localparam logic OH_FILL    = 1'b1;

  logic clk = 1'b0;
  logic rst, bitEn, midEn, clkMode, ohFromSer, ohUseInt, serIn, ohIn;
  logic txOut, txOutOh, txTiming;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;
  int mSlot = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;  // 125 MHz

  tx_payload_in #(.FRAME_BITS(FRAME_BITS), .OH_FILL(OH_FILL)) uut (
    .clk(clk), .rst(rst), .bitEn(bitEn), .midEn(midEn), .clkMode(clkMode),
    .ohFromSer(ohFromSer), .ohUseInt(ohUseInt), .serIn(serIn), .ohIn(ohIn),
    .txOut(txOut), .txOutOh(txOutOh), .txTiming(txTiming)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic act, input logic exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b (slot %0d)", req, what, act, exp, mSlot);
    end
  endtask

  task automatic nextRand(output logic b);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    b = lfsr[0];
  endtask

  task automatic doReset(input logic mode, input logic fromSer, input logic useInt);
    @(negedge clk);
    rst = 1'b1; bitEn = 1'b0; midEn = 1'b0; serIn = 1'b0; ohIn = 1'b0;
    clkMode = mode; ohFromSer = fromSer; ohUseInt = useInt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mSlot = 0;
  endtask

  // One bit period of four cycles: bitEn, idle, midEn, idle
  task automatic stepBit(input logic serV, input logic ohV);
    bit isOh, preOh;
    logic expBit, expPin, ohExp;
    string ohReq;
    isOh  = (mSlot == 0);
    preOh = (mSlot == FRAME_BITS - 1);
    if (ohFromSer)     begin ohExp = serV;    ohReq = "R6"; end
    else if (ohUseInt) begin ohExp = OH_FILL; ohReq = "R7"; end
    else               begin ohExp = ohV;     ohReq = "R8"; end
    expBit = isOh ? ohExp : serV;
    expPin = clkMode ? !preOh : preOh;
    bitEn = 1'b1; serIn = serV; ohIn = ohV;
    @(negedge clk);
    bitEn = 1'b0;
    check(txOut === expBit, isOh ? ohReq : "R3", "txOut", txOut, expBit);
    check(txOutOh === isOh, "R2", "txOutOh", txOutOh, isOh);
    check(txTiming === expPin, clkMode ? "R5" : "R4", "txTiming at bit start", txTiming, expPin);
    serIn = ~serV; ohIn = ~ohV;
    @(negedge clk);
    check(txOut === expBit, "R9", "txOut held", txOut, expBit);
    check(txTiming === expPin, "R9", "txTiming held", txTiming, expPin);
    midEn = 1'b1;
    @(negedge clk);
    midEn = 1'b0;
    expPin = clkMode ? 1'b0 : preOh;
    check(txTiming === expPin, clkMode ? "R5" : "R4", "txTiming after mid", txTiming, expPin);
    check(txOut === expBit, "R9", "txOut after mid", txOut, expBit);
    @(negedge clk);
    mSlot = (mSlot + 1) % FRAME_BITS;
  endtask

  task automatic runBits(input int n);
    logic s;
    for (int i = 0; i < n; i++) begin
      nextRand(s);
      stepBit(s, ~s);  // overhead pin always opposite to serial input
    end
  endtask

  task automatic testReset();
    doReset(1'b1, 1'b0, 1'b0);
    check(txOut === 1'b0, "R1", "txOut after reset", txOut, 1'b0);
    check(txOutOh === 1'b0, "R1", "txOutOh after reset", txOutOh, 1'b0);
    check(txTiming === 1'b0, "R1", "txTiming after reset", txTiming, 1'b0);
    stepBit(1'b0, 1'b1);  // first slot is overhead: takes ohIn
    check(txOutOh === 1'b1 && txOut === 1'b1, "R1", "first slot overhead", txOut, 1'b1);
  endtask

  task automatic testStrobeMode();
    doReset(1'b0, 1'b0, 1'b0);
    runBits(2 * FRAME_BITS + 3);
  endtask

  task automatic testClockMode();
    doReset(1'b1, 1'b0, 1'b1);
    runBits(2 * FRAME_BITS + 3);
  endtask

  task automatic testSerialOverhead();
    doReset(1'b0, 1'b1, 1'b0);
    stepBit(1'b1, 1'b0);
    stepBit(1'b0, 1'b1);
    runBits(FRAME_BITS - 2);
    stepBit(1'b0, 1'b1);  // overhead of second block taken from serIn
  endtask

  task automatic testFillIgnoresInputs();
    doReset(1'b0, 1'b0, 1'b1);
    stepBit(1'b0, 1'b0);  // R7: both inputs low, overhead is still OH_FILL
    check(txOut === OH_FILL, "R7", "fill with inputs low", txOut, OH_FILL);
  endtask

  initial begin
    testReset();
    testStrobeMode();
    testClockMode();
    testSerialOverhead();
    testFillIgnoresInputs();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule